// File: doc/BRIEF.md
# Opcode-Menu Software Flash Sequencer

This block runs one serial-flash command at a time on behalf of software. Software first loads an eight-entry opcode table and a 2-bit type for each entry. It then starts a cycle by writing an index into that table, together with a few option bits, to the control word. The type of the chosen entry decides two things: whether a 24-bit address follows the opcode, and whether the data bytes are received from the flash or sent to it.

A write-type command may be preceded by one of two stored prefix opcodes, for example a write-enable. The prefix goes out in a frame of its own. Chip select is then dropped for at least one cycle, and the main command follows in a second frame with no further action from software.

Toward the serial shifter the block presents a byte stream with a valid/ready handshake, a direction flag and a chip-select level. Data bytes move to and from a data buffer that is shared with the hardware sequencer, addressed one byte at a time. The flash address comes in from that same shared side. A lock input freezes the opcode table and the prefix register.

Top module: `sw_flash_seq`

## Requirements
- R1: After reset, all four registers read as zero, and both chip select and byte valid are low.
- R2: Register index 2 holds table entries 0..3 and index 3 holds entries 4..7, with entry i at byte i mod 4. Index 1 holds prefix 0 in bits 7:0, prefix 1 in bits 15:8, and the type of entry i in bits 17+2i:16+2i. All three read back what was written.
- R3: Writing 1 to control bit 9 (index 0) starts a cycle. The first byte of the main frame is the table entry selected by control bits 14:12.
- R4: Type codes are 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address. Types 2 and 3 send the flash address as three bytes, most significant first, right after the opcode; types 0 and 1 send no address.
- R5: Control bit 22 enables the data phase, and bits 21:16 hold the byte count minus one (1 to 64 bytes). Read types receive byte k into buffer location k; write types send buffer location k. With bit 22 clear, no data byte moves.
- R6: With bit 10 set and a write type, the prefix from slot 1 (bit 11 = 1) or slot 0 (bit 11 = 0) is sent alone in its own frame. Chip select is then released before the main frame begins.
- R7: Bit 10 set together with a read type sets the cycle-error bit 3 and the done bit 2, and no byte is sent.
- R8: Status bit 0 (busy) is high from the accepted start until the last byte. Done (bit 2) is set when the cycle ends. Writing 1 to bit 2, 3 or 4 clears that bit.
- R9: A start written while busy is ignored: the running cycle continues unchanged, the control fields keep their values, and the access-error bit 4 is set.
- R10: While the lock input is high, writes to register indexes 1, 2 and 3 have no effect, and cycles still run from the stored table.
- R11: A byte moves on a cycle where valid and ready are both high. Valid is high only while chip select is high, and a byte that is not accepted stays valid with the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Freezes opcode table and prefix register |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| flash_addr_i | input | 24 | Flash address from the shared address register |
| spi_sel_o | output | 1 | Chip-select level toward the shifter |
| spi_valid_o | output | 1 | Byte request valid |
| spi_rx_o | output | 1 | 1 = receive a byte, 0 = send spi_wdata_o |
| spi_wdata_o | output | 8 | Byte to send |
| spi_ready_i | input | 1 | Shifter accepts or completes the byte |
| spi_rdata_i | input | 8 | Received byte, valid with ready on a receive |
| buf_idx_o | output | 6 | Shared buffer byte location |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Byte to store in the buffer |
| buf_rdata_i | input | 8 | Buffer byte at buf_idx_o |

## Verification
Cycles are run with each of the four types, and with and without the data phase. A receive read with no address is compared against an addressed read that has data disabled but a non-zero length field. This shows that the enable bit, not the length, gates the data phase, and that only types 2 and 3 add address bytes. Atomic cycles use both prefix slots, and each byte is tagged with whether chip select was dropped before it, so a missing release between the prefix and main frames is caught. Further runs cover a prefix requested on a read type, a second start during a stalled cycle, writes under lock, and a full 64-byte read.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int REG_CTRL = 0;
    localparam int REG_PFX  = 1;
    localparam int REG_MLO  = 2;
    localparam int REG_MHI  = 3;

    localparam int B_BUSY   = 0;
    localparam int B_DONE   = 2;
    localparam int B_CERR   = 3;
    localparam int B_AERR   = 4;
    localparam int B_GO     = 9;
    localparam int B_ATOM   = 10;
    localparam int B_PSEL   = 11;
    localparam int B_IDX    = 12;
    localparam int B_LEN    = 16;
    localparam int B_DEN    = 22;
    localparam int B_TYPES  = 16;

    localparam int IDX_W    = 3;
    localparam int LEN_W    = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_GAP,
        ST_OPC,
        ST_ADR,
        ST_DAT
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             atomic;
        logic             psel;
        logic             den;
        logic [LEN_W-1:0] dlen;
    } cyc_cfg_t;

endpackage

// File: rtl/sfs_regs.sv
module sfs_regs
    import sfs_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lock_i,
    input  logic           we_i,
    input  logic [RAW-1:0] addr_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o,
    input  logic           eng_busy_i,
    input  logic           eng_fin_i,
    input  logic           eng_cerr_i,
    output logic           start_o,
    output cyc_cfg_t       cfg_o,
    output logic [DW-1:0]  menu_lo_o,
    output logic [DW-1:0]  menu_hi_o,
    output logic [DW-1:0]  pfx_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           cerr_o,
    output logic           aerr_o
);

    typedef struct packed {
        cyc_cfg_t      cfg;
        logic          start;
        logic          done;
        logic          cerr;
        logic          aerr;
        logic [DW-1:0] mlo;
        logic [DW-1:0] mhi;
        logic [DW-1:0] pfx;
    } regs_t;

    regs_t q, d;
    logic  busy;
    logic  ctrl_wr;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        busy    = q.start | eng_busy_i;
        ctrl_wr = we_i && (addr_i == RAW'(REG_CTRL));

        if (ctrl_wr) begin
            if (wdata_i[B_DONE]) d.done = 1'b0;
            if (wdata_i[B_CERR]) d.cerr = 1'b0;
            if (wdata_i[B_AERR]) d.aerr = 1'b0;
            if (!busy) begin
                d.cfg.idx    = wdata_i[B_IDX +: IDX_W];
                d.cfg.atomic = wdata_i[B_ATOM];
                d.cfg.psel   = wdata_i[B_PSEL];
                d.cfg.den    = wdata_i[B_DEN];
                d.cfg.dlen   = wdata_i[B_LEN +: LEN_W];
                d.start      = wdata_i[B_GO];
            end else if (wdata_i[B_GO]) begin
                d.aerr = 1'b1;
            end
        end

        if (eng_fin_i) begin
            d.done = 1'b1;
            if (eng_cerr_i) d.cerr = 1'b1;
        end

        if (we_i && !lock_i) begin
            if (addr_i == RAW'(REG_PFX)) d.pfx = wdata_i;
            if (addr_i == RAW'(REG_MLO)) d.mlo = wdata_i;
            if (addr_i == RAW'(REG_MHI)) d.mhi = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RAW'(REG_CTRL): begin
                rdata_o[B_BUSY]           = busy;
                rdata_o[B_DONE]           = q.done;
                rdata_o[B_CERR]           = q.cerr;
                rdata_o[B_AERR]           = q.aerr;
                rdata_o[B_ATOM]           = q.cfg.atomic;
                rdata_o[B_PSEL]           = q.cfg.psel;
                rdata_o[B_IDX +: IDX_W]   = q.cfg.idx;
                rdata_o[B_LEN +: LEN_W]   = q.cfg.dlen;
                rdata_o[B_DEN]            = q.cfg.den;
            end
            RAW'(REG_PFX): rdata_o = q.pfx;
            RAW'(REG_MLO): rdata_o = q.mlo;
            default:       rdata_o = q.mhi;
        endcase
    end

    assign start_o   = q.start;
    assign cfg_o     = q.cfg;
    assign menu_lo_o = q.mlo;
    assign menu_hi_o = q.mhi;
    assign pfx_o     = q.pfx;
    assign busy_o    = busy;
    assign done_o    = q.done;
    assign cerr_o    = q.cerr;
    assign aerr_o    = q.aerr;

endmodule

// File: rtl/sfs_engine.sv
module sfs_engine
    import sfs_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int BUF_AW     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [7:0]              opcode_i,
    input  logic [1:0]              type_i,
    input  logic [7:0]              prefix_i,
    input  logic                    atomic_i,
    input  logic                    den_i,
    input  logic [BUF_AW-1:0]       dlen_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic                    ready_i,
    input  logic [7:0]              rdata_i,
    input  logic [7:0]              buf_rdata_i,
    output logic                    busy_o,
    output logic                    fin_o,
    output logic                    cerr_o,
    output logic                    sel_o,
    output logic                    valid_o,
    output logic                    rx_o,
    output logic [7:0]              wdata_o,
    output logic [BUF_AW-1:0]       buf_idx_o,
    output logic                    buf_we_o,
    output logic [7:0]              buf_wdata_o
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam logic [BUF_AW-1:0] ADDR_LAST = BUF_AW'(ADDR_BYTES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [7:0]        op;
        logic [1:0]        typ;
        logic [7:0]        pre;
        logic              den;
        logic [BUF_AW-1:0] dlen;
        logic [ADDR_W-1:0] addr;
        logic [BUF_AW-1:0] cnt;
    } eng_t;

    eng_t q, d;
    logic is_write;

    assign is_write = q.typ[0];

    always_comb begin
        d           = q;
        fin_o       = 1'b0;
        cerr_o      = 1'b0;
        valid_o     = 1'b0;
        rx_o        = 1'b0;
        wdata_o     = 8'h00;
        buf_idx_o   = q.cnt;
        buf_we_o    = 1'b0;
        buf_wdata_o = rdata_i;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.op   = opcode_i;
                    d.typ  = type_i;
                    d.pre  = prefix_i;
                    d.den  = den_i;
                    d.dlen = dlen_i;
                    d.addr = addr_i;
                    d.cnt  = '0;
                    if (atomic_i && !type_i[0]) begin
                        fin_o  = 1'b1;
                        cerr_o = 1'b1;
                    end else begin
                        d.st = atomic_i ? ST_PRE : ST_OPC;
                    end
                end
            end
            ST_PRE: begin
                valid_o = 1'b1;
                wdata_o = q.pre;
                if (ready_i) d.st = ST_GAP;
            end
            ST_GAP: begin
                d.st = ST_OPC;
            end
            ST_OPC: begin
                valid_o = 1'b1;
                wdata_o = q.op;
                if (ready_i) begin
                    d.cnt = '0;
                    if (q.typ[1]) begin
                        d.st = ST_ADR;
                    end else if (q.den) begin
                        d.st = ST_DAT;
                    end else begin
                        d.st  = ST_IDLE;
                        fin_o = 1'b1;
                    end
                end
            end
            ST_ADR: begin
                valid_o = 1'b1;
                wdata_o = q.addr[ADDR_W-1 -: 8];
                if (ready_i) begin
                    d.addr = q.addr << 8;
                    if (q.cnt == ADDR_LAST) begin
                        d.cnt = '0;
                        if (q.den) begin
                            d.st = ST_DAT;
                        end else begin
                            d.st  = ST_IDLE;
                            fin_o = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DAT: begin
                valid_o  = 1'b1;
                rx_o     = !is_write;
                wdata_o  = is_write ? buf_rdata_i : 8'h00;
                buf_we_o = !is_write && ready_i;
                if (ready_i) begin
                    if (q.cnt == q.dlen) begin
                        d.st  = ST_IDLE;
                        fin_o = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.st != ST_IDLE);
    assign sel_o  = (q.st == ST_PRE) || (q.st == ST_OPC) ||
                    (q.st == ST_ADR) || (q.st == ST_DAT);

endmodule

// File: rtl/sw_flash_seq.sv
module sw_flash_seq
    import sfs_pkg::*;
#(
    parameter int NUM_OPS    = 8,
    parameter int ADDR_BYTES = 3,
    parameter int BUF_AW     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_i,
    input  logic                    reg_we_i,
    input  logic [1:0]              reg_addr_i,
    input  logic [31:0]             reg_wdata_i,
    output logic [31:0]             reg_rdata_o,
    input  logic [8*ADDR_BYTES-1:0] flash_addr_i,
    output logic                    spi_sel_o,
    output logic                    spi_valid_o,
    output logic                    spi_rx_o,
    output logic [7:0]              spi_wdata_o,
    input  logic                    spi_ready_i,
    input  logic [7:0]              spi_rdata_i,
    output logic [BUF_AW-1:0]       buf_idx_o,
    output logic                    buf_we_o,
    output logic [7:0]              buf_wdata_o,
    input  logic [7:0]              buf_rdata_i
);

    localparam int MENU_W = 8 * NUM_OPS;

    cyc_cfg_t    cfg;
    logic        start;
    logic [31:0] menu_lo, menu_hi, pfx_q;
    logic        sts_busy, sts_done, sts_cerr, sts_aerr;
    logic        eng_busy, eng_fin, eng_cerr;

    logic [MENU_W-1:0] menu_all;
    logic [7:0]        op_tbl  [NUM_OPS];
    logic [1:0]        typ_tbl [NUM_OPS];

    assign menu_all = {menu_hi, menu_lo};

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_tbl
        assign op_tbl[i]  = menu_all[8*i +: 8];
        assign typ_tbl[i] = pfx_q[B_TYPES + 2*i +: 2];
    end

    sfs_regs #(.DW(32), .RAW(2)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (lock_i),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .eng_busy_i (eng_busy),
        .eng_fin_i  (eng_fin),
        .eng_cerr_i (eng_cerr),
        .start_o    (start),
        .cfg_o      (cfg),
        .menu_lo_o  (menu_lo),
        .menu_hi_o  (menu_hi),
        .pfx_o      (pfx_q),
        .busy_o     (sts_busy),
        .done_o     (sts_done),
        .cerr_o     (sts_cerr),
        .aerr_o     (sts_aerr)
    );

    sfs_engine #(.ADDR_BYTES(ADDR_BYTES), .BUF_AW(BUF_AW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .opcode_i    (op_tbl[cfg.idx]),
        .type_i      (typ_tbl[cfg.idx]),
        .prefix_i    (cfg.psel ? pfx_q[15:8] : pfx_q[7:0]),
        .atomic_i    (cfg.atomic),
        .den_i       (cfg.den),
        .dlen_i      (BUF_AW'(cfg.dlen)),
        .addr_i      (flash_addr_i),
        .ready_i     (spi_ready_i),
        .rdata_i     (spi_rdata_i),
        .buf_rdata_i (buf_rdata_i),
        .busy_o      (eng_busy),
        .fin_o       (eng_fin),
        .cerr_o      (eng_cerr),
        .sel_o       (spi_sel_o),
        .valid_o     (spi_valid_o),
        .rx_o        (spi_rx_o),
        .wdata_o     (spi_wdata_o),
        .buf_idx_o   (buf_idx_o),
        .buf_we_o    (buf_we_o),
        .buf_wdata_o (buf_wdata_o)
    );

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lock_i,
    input logic        spi_sel_o,
    input logic        spi_valid_o,
    input logic        spi_ready_i,
    input logic [7:0]  spi_wdata_o,
    input logic        sts_busy,
    input logic        sts_done,
    input logic        sts_cerr,
    input logic [31:0] menu_lo,
    input logic [31:0] menu_hi,
    input logic [31:0] pfx_q
);

    a_r11_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_valid_o |-> spi_sel_o);

    a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_valid_o && !spi_ready_i) |=> (spi_valid_o && $stable(spi_wdata_o)));

    a_r8_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel_o |-> sts_busy);

    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_busy) |-> sts_done);

    a_r7_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_cerr) |-> !spi_sel_o);

    a_r10_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_i) |-> ($stable(menu_lo) && $stable(menu_hi) && $stable(pfx_q)));

endmodule

bind sw_flash_seq sfs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_i      (lock_i),
    .spi_sel_o   (spi_sel_o),
    .spi_valid_o (spi_valid_o),
    .spi_ready_i (spi_ready_i),
    .spi_wdata_o (spi_wdata_o),
    .sts_busy    (sts_busy),
    .sts_done    (sts_done),
    .sts_cerr    (sts_cerr),
    .menu_lo     (menu_lo),
    .menu_hi     (menu_hi),
    .pfx_q       (pfx_q)
);

// File: tb/sim_sw_flash_seq.sv
module sim_sw_flash_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [23:0] flash_addr_i = '0;
    logic        spi_sel_o, spi_valid_o, spi_rx_o;
    logic [7:0]  spi_wdata_o;
    logic        spi_ready_i;
    logic [7:0]  spi_rdata_i;
    logic [5:0]  buf_idx_o;
    logic        buf_we_o;
    logic [7:0]  buf_wdata_o;
    logic [7:0]  buf_rdata_i;

    always #4 clk = ~clk;

    sw_flash_seq u0 (.*);

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    logic        stall = 1'b0;
    logic [7:0]  rxcnt = 8'h00;
    logic [7:0]  mem [64];
    logic [9:0]  exp_q [$];
    string       tag_q [$];
    logic        gap = 1'b1;

    assign spi_ready_i = !stall && ((cyc % 3) != 1);
    assign spi_rdata_i = 8'h5A ^ rxcnt;
    assign buf_rdata_i = mem[buf_idx_o];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (spi_valid_o && spi_ready_i && spi_rx_o) rxcnt <= rxcnt + 8'h01;
        if (buf_we_o) mem[buf_idx_o] <= buf_wdata_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: item = {new_frame, receive, byte}
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_sel_o) gap = 1'b1;
            if (spi_valid_o && spi_ready_i) begin
                logic [9:0] got;
                got = {gap, spi_rx_o, spi_wdata_o};
                gap = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected byte", 32'(got), 32'h0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e[8]) chk(got[9:8] == e[9:8], t, 32'(got), 32'(e));
                    else      chk(got == e, t, 32'(got), 32'(e));
                end
            end
        end
    end

    task automatic push(input bit nf, input bit rx, input logic [7:0] b, input string t);
        exp_q.push_back({nf, rx, b});
        tag_q.push_back(t);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
        @(posedge clk); #1;
        reg_we_i = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        reg_addr_i = a;
        @(negedge clk);
        v = reg_rdata_o;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(2'd0, v);
            if (!v[0]) break;
        end
    endtask

    function automatic logic [31:0] ctl(input int idx, input bit at, input bit ps, input bit den, input int len);
        return (32'(den) << 22) | (32'((len - 1) & 63) << 16) | (32'(idx) << 12) |
               (32'(ps) << 11) | (32'(at) << 10) | 32'h200;
    endfunction

    task automatic queue_empty(input string t);
        chk(exp_q.size() == 0, t, 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  base;
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), v);
            chk(v == 32'h0, "R1 register after reset", v, 32'h0);
        end
        chk(!spi_sel_o && !spi_valid_o, "R1 select/valid low", {30'h0, spi_sel_o, spi_valid_o}, 32'h0);

        // R2 table and prefix/types
        reg_wr(2'd2, 32'h02030105);
        reg_wr(2'd3, 32'h35C7D89F);
        reg_wr(2'd1, 32'h1CE45006);
        reg_rd(2'd2, v); chk(v == 32'h02030105, "R2 menu low", v, 32'h02030105);
        reg_rd(2'd3, v); chk(v == 32'h35C7D89F, "R2 menu high", v, 32'h35C7D89F);
        reg_rd(2'd1, v); chk(v == 32'h1CE45006, "R2 prefix/types", v, 32'h1CE45006);

        // R3/R5: entry 4 (0x9F, type 0), 3 bytes received
        base = rxcnt;
        push(1, 0, 8'h9F, "R3 opcode by index");
        for (int k = 0; k < 3; k++) push(0, 1, 8'h00, "R5 receive byte");
        reg_wr(2'd0, ctl(4, 0, 0, 1, 3));
        reg_rd(2'd0, v); chk(v[0] == 1'b1, "R8 busy during cycle", v, 32'h1);
        wait_idle();
        queue_empty("R3 all bytes seen");
        for (int k = 0; k < 3; k++)
            chk(mem[k] == (8'h5A ^ (base + 8'(k))), "R5 buffer store", 32'(mem[k]), 32'(8'h5A ^ (base + 8'(k))));
        reg_rd(2'd0, v); chk(v[2] == 1'b1, "R8 done set", v, 32'h4);
        reg_wr(2'd0, 32'h4);
        reg_rd(2'd0, v); chk(v[2] == 1'b0, "R8 done W1C", v, 32'h0);

        // R4/R5: entry 2 (0x03, type 2), data disabled with length field 8
        flash_addr_i = 24'h123456;
        push(1, 0, 8'h03, "R4 opcode");
        push(0, 0, 8'h12, "R4 addr high");
        push(0, 0, 8'h34, "R4 addr mid");
        push(0, 0, 8'h56, "R4 addr low");
        reg_wr(2'd0, ctl(2, 0, 0, 0, 8));
        wait_idle();
        queue_empty("R5 no data when disabled");

        // R6: entry 3 (0x02, type 3), atomic slot 1, write 4 bytes
        mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h33; mem[3] = 8'h44;
        flash_addr_i = 24'hABCDEF;
        push(1, 0, 8'h50, "R6 prefix slot 1");
        push(1, 0, 8'h02, "R6 new frame for command");
        push(0, 0, 8'hAB, "R4 addr");
        push(0, 0, 8'hCD, "R4 addr");
        push(0, 0, 8'hEF, "R4 addr");
        push(0, 0, 8'h11, "R5 send buffer");
        push(0, 0, 8'h22, "R5 send buffer");
        push(0, 0, 8'h33, "R5 send buffer");
        push(0, 0, 8'h44, "R5 send buffer");
        reg_wr(2'd0, ctl(3, 1, 1, 1, 4));
        wait_idle();
        queue_empty("R6 atomic write complete");

        // R6: entry 6 (0xC7, type 1), atomic slot 0
        push(1, 0, 8'h06, "R6 prefix slot 0");
        push(1, 0, 8'hC7, "R6 command after release");
        reg_wr(2'd0, ctl(6, 1, 0, 0, 1));
        wait_idle();
        queue_empty("R6 atomic no-data complete");
        reg_wr(2'd0, 32'h1C);

        // R7: atomic with read type entry 0
        reg_wr(2'd0, ctl(0, 1, 0, 0, 1));
        wait_idle();
        reg_rd(2'd0, v);
        chk(v[3] == 1'b1 && v[2] == 1'b1, "R7 cycle error and done", v & 32'hC, 32'hC);
        queue_empty("R7 nothing sent");
        reg_wr(2'd0, 32'h1C);
        reg_rd(2'd0, v); chk(v[4:2] == 3'b000, "R8 error bits W1C", v & 32'h1C, 32'h0);

        // R9: second start while stalled
        stall = 1'b1;
        push(1, 0, 8'h05, "R9 original cycle only");
        reg_wr(2'd0, ctl(0, 0, 0, 0, 1));
        repeat (3) @(posedge clk);
        reg_wr(2'd0, ctl(5, 0, 1, 1, 9));
        reg_rd(2'd0, v);
        chk(v[4] == 1'b1 && v[0] == 1'b1, "R9 access error while busy", v & 32'h11, 32'h11);
        chk(v[14:12] == 3'd0 && v[22] == 1'b0, "R9 fields kept", v & 32'h407000, 32'h0);
        stall = 1'b0;
        wait_idle();
        queue_empty("R9 no restart");
        reg_wr(2'd0, 32'h1C);

        // R10: lock
        lock_i = 1'b1;
        reg_wr(2'd2, 32'hFFFFFFFF);
        reg_wr(2'd1, 32'h00000000);
        reg_rd(2'd2, v); chk(v == 32'h02030105, "R10 menu locked", v, 32'h02030105);
        reg_rd(2'd1, v); chk(v == 32'h1CE45006, "R10 prefix locked", v, 32'h1CE45006);
        push(1, 0, 8'h05, "R10 cycle under lock");
        reg_wr(2'd0, ctl(0, 0, 0, 0, 1));
        wait_idle();
        queue_empty("R10 cycle done");
        lock_i = 1'b0;

        // R5 boundary: entry 7 (0x35, type 0), 64 bytes
        base = rxcnt;
        push(1, 0, 8'h35, "R3 opcode entry 7");
        for (int k = 0; k < 64; k++) push(0, 1, 8'h00, "R5 64-byte read");
        reg_wr(2'd0, ctl(7, 0, 0, 1, 64));
        wait_idle();
        queue_empty("R5 64 bytes");
        chk(mem[0] == (8'h5A ^ base), "R5 first of 64", 32'(mem[0]), 32'(8'h5A ^ base));
        chk(mem[63] == (8'h5A ^ (base + 8'd63)), "R5 last of 64", 32'(mem[63]), 32'(8'h5A ^ (base + 8'd63)));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule